// File: doc/BRIEF.md
# Conditioned loop current calculator

This block forms one signed loop current value from four signed branch-current samples each time a sample strobe arrives. Two of the branches can be forced to zero first. Which one depends on a common-mode-high status flag and on the 3-bit linefeed state code. The block then forms a signed difference of the four branches.

In the two open states the difference is used whole. In every other state it is halved. The result is clamped to the signed 16-bit range and registered, and a one-cycle valid pulse marks each new value. The block sits between the current monitoring front end and the loop closure filter.

Top module: `loop_current_calc`

## Requirements
- R1: When `cmh_i` is 1 and `lfs_i` is 1 (forward active) or 3 (tip open), the Q1 branch current is treated as zero.
- R2: When `cmh_i` is 1 and `lfs_i` is 5 (reverse active) or 7 (ring open), the Q2 branch current is treated as zero.
- R3: When `cmh_i` is 0, or when `lfs_i` is 0, 2, 4 or 6, no branch is forced to zero and all four branches contribute.
- R4: The raw sum is Q1 − Q6 + Q5 − Q2. It uses the conditioned branch values, all in 16-bit two's complement, and is formed without overflow in 18 bits.
- R5: When `lfs_i` is 3 or 7, the sum is used undivided. For every other code it is halved by an arithmetic right shift, which rounds toward minus infinity.
- R6: A result above 32767 gives 32767 on `loop_o`. A result below −32768 gives −32768.
- R7: `loop_o` takes the new value, and `loop_vld_o` is 1, in the cycle after a clock edge at which `sample_vld_i` is 1. If `sample_vld_i` is 0 at an edge, `loop_vld_o` is 0 in the next cycle and `loop_o` keeps its value, whatever the other inputs do.
- R8: While reset is held, and after it is released, `loop_o` reads 0 and `loop_vld_o` reads 0 until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| sample_vld_i | input | 1 | Sample strobe: the branch inputs are valid at this edge |
| iq1_i | input | 16 | Q1 branch current, signed |
| iq2_i | input | 16 | Q2 branch current, signed |
| iq5_i | input | 16 | Q5 branch current, signed |
| iq6_i | input | 16 | Q6 branch current, signed |
| cmh_i | input | 1 | Common-mode-high status flag |
| lfs_i | input | 3 | Linefeed state code |
| loop_o | output | 16 | Loop current, signed and saturated |
| loop_vld_o | output | 1 | One-cycle pulse marking a new `loop_o` |

## Verification
Every result has a latency of exactly one register. The loop current and its valid pulse appear after the clock edge that captured the strobe. Once the strobe is dropped, the hold value and the low valid apply from the following edge onward.

The bench drives inputs on the falling edge and lets one rising edge pass. It then compares the outputs on the next falling edge against a value computed by a bench function from the requirements. For the hold case, it changes the inputs with the strobe low and checks the unchanged output one edge later.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  localparam int unsigned LFS_W = 3;

  typedef enum logic [LFS_W-1:0] {
    LF_IDLE_0    = 3'd0,
    LF_FWD_ACT   = 3'd1,
    LF_MISC_2    = 3'd2,
    LF_TIP_OPEN  = 3'd3,
    LF_MISC_4    = 3'd4,
    LF_REV_ACT   = 3'd5,
    LF_MISC_6    = 3'd6,
    LF_RING_OPEN = 3'd7
  } lf_state_e;

  function automatic logic lf_is_open(input logic [LFS_W-1:0] code);
    return (code == LF_TIP_OPEN) || (code == LF_RING_OPEN);
  endfunction

  function automatic logic lf_drops_q1(input logic cmh, input logic [LFS_W-1:0] code);
    return cmh && ((code == LF_FWD_ACT) || (code == LF_TIP_OPEN));
  endfunction

  function automatic logic lf_drops_q2(input logic cmh, input logic [LFS_W-1:0] code);
    return cmh && ((code == LF_REV_ACT) || (code == LF_RING_OPEN));
  endfunction
endpackage

// File: rtl/lcc_branch_gate.sv
module lcc_branch_gate
  import lcc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              cmh_i,
  input  logic [LFS_W-1:0]  lfs_i,
  input  logic [DATA_W-1:0] iq1_i,
  input  logic [DATA_W-1:0] iq2_i,
  output logic [DATA_W-1:0] q1_o,
  output logic [DATA_W-1:0] q2_o
);
  logic drop_q1;
  logic drop_q2;

  always_comb begin
    drop_q1 = lf_drops_q1(cmh_i, lfs_i);
    drop_q2 = lf_drops_q2(cmh_i, lfs_i);
    q1_o    = drop_q1 ? '0 : iq1_i;
    q2_o    = drop_q2 ? '0 : iq2_i;
  end
endmodule

// File: rtl/lcc_combiner.sv
module lcc_combiner #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SUM_W  = DATA_W + 2
) (
  input  logic [DATA_W-1:0] q1_i,
  input  logic [DATA_W-1:0] q2_i,
  input  logic [DATA_W-1:0] q5_i,
  input  logic [DATA_W-1:0] q6_i,
  input  logic              open_i,
  output logic [SUM_W-1:0]  scaled_o,
  output logic [DATA_W-1:0] sat_o
);
  localparam int unsigned EXT_W = SUM_W - DATA_W;
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(2 ** (DATA_W - 1));

  logic signed [SUM_W-1:0] e1, e2, e5, e6;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] scaled;

  always_comb begin
    e1 = {{EXT_W{q1_i[DATA_W-1]}}, q1_i};
    e2 = {{EXT_W{q2_i[DATA_W-1]}}, q2_i};
    e5 = {{EXT_W{q5_i[DATA_W-1]}}, q5_i};
    e6 = {{EXT_W{q6_i[DATA_W-1]}}, q6_i};
    sum = e1 - e6 + e5 - e2;
    scaled = open_i ? sum : (sum >>> 1);
    if (scaled > MAX_V)      sat_o = MAX_V[DATA_W-1:0];
    else if (scaled < MIN_V) sat_o = MIN_V[DATA_W-1:0];
    else                     sat_o = scaled[DATA_W-1:0];
    scaled_o = scaled;
  end
endmodule

// File: rtl/loop_current_calc.sv
module loop_current_calc
  import lcc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_vld_i,
  input  logic [DATA_W-1:0] iq1_i,
  input  logic [DATA_W-1:0] iq2_i,
  input  logic [DATA_W-1:0] iq5_i,
  input  logic [DATA_W-1:0] iq6_i,
  input  logic              cmh_i,
  input  logic [LFS_W-1:0]  lfs_i,
  output logic [DATA_W-1:0] loop_o,
  output logic              loop_vld_o
);
  localparam int unsigned SUM_W = DATA_W + 2;
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(2 ** (DATA_W - 1));

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DATA_W-1:0] q1_c, q2_c;
  logic [SUM_W-1:0]  scaled_c;
  logic [DATA_W-1:0] sat_c;

  lcc_branch_gate #(.DATA_W(DATA_W)) u_gate (
    .cmh_i (cmh_i),
    .lfs_i (lfs_i),
    .iq1_i (iq1_i),
    .iq2_i (iq2_i),
    .q1_o  (q1_c),
    .q2_o  (q2_c)
  );

  lcc_combiner #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_comb (
    .q1_i     (q1_c),
    .q2_i     (q2_c),
    .q5_i     (iq5_i),
    .q6_i     (iq6_i),
    .open_i   (lf_is_open(lfs_i)),
    .scaled_o (scaled_c),
    .sat_o    (sat_c)
  );

  logic [DATA_W-1:0] loop_d, loop_q;
  logic              vld_d, vld_q;

  always_comb begin
    loop_d = loop_q;
    if (sample_vld_i) loop_d = sat_c;
    vld_d = sample_vld_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      loop_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      loop_q <= loop_d;
      vld_q  <= vld_d;
    end
  end

  assign loop_o     = loop_q;
  assign loop_vld_o = vld_q;

  assert_q1_drop_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmh_i && (lfs_i == LF_FWD_ACT || lfs_i == LF_TIP_OPEN)) |-> (q1_c == '0));
  assert_q2_drop_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmh_i && (lfs_i == LF_REV_ACT || lfs_i == LF_RING_OPEN)) |-> (q2_c == '0));
  assert_no_drop_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cmh_i || !lfs_i[0]) |-> (q1_c == iq1_i && q2_c == iq2_i));
  assert_sat_high_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($signed(scaled_c) > MAX_V) |-> (sat_c == MAX_V[DATA_W-1:0]));
  assert_sat_low_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($signed(scaled_c) < MIN_V) |-> (sat_c == MIN_V[DATA_W-1:0]));
  assert_vld_pulse_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_vld_i |=> loop_vld_o);
  assert_vld_quiet_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sample_vld_i |=> !loop_vld_o);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sample_vld_i |=> $stable(loop_o));
endmodule

// File: tb/loop_current_calc_bench.sv
module loop_current_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_vld_i;
  logic [15:0] iq1_i, iq2_i, iq5_i, iq6_i;
  logic        cmh_i;
  logic [2:0]  lfs_i;
  logic [15:0] loop_o;
  logic        loop_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  loop_current_calc u_loop_current_calc (
    .clk(clk), .rst_n(rst_n), .sample_vld_i(sample_vld_i),
    .iq1_i(iq1_i), .iq2_i(iq2_i), .iq5_i(iq5_i), .iq6_i(iq6_i),
    .cmh_i(cmh_i), .lfs_i(lfs_i), .loop_o(loop_o), .loop_vld_o(loop_vld_o)
  );

  function automatic int exp_loop(int q1, int q2, int q5, int q6, bit cmh, int lf);
    int a, b, s;
    a = (cmh && (lf == 1 || lf == 3)) ? 0 : q1;
    b = (cmh && (lf == 5 || lf == 7)) ? 0 : q2;
    s = a - q6 + q5 - b;
    if (!(lf == 3 || lf == 7)) s = s >>> 1;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(string req, int q1, int q2, int q5, int q6, bit cmh, int lf);
    @(negedge clk);
    iq1_i = 16'(q1); iq2_i = 16'(q2); iq5_i = 16'(q5); iq6_i = 16'(q6);
    cmh_i = cmh; lfs_i = 3'(lf); sample_vld_i = 1'b1;
    @(negedge clk);
    sample_vld_i = 1'b0;
    check({req, " valid"}, int'(loop_vld_o), 1);
    check(req, int'($signed(loop_o)), exp_loop(q1, q2, q5, q6, cmh, lf));
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 1'b0; sample_vld_i = 1'b0; cmh_i = 1'b0; lfs_i = '0;
    iq1_i = '0; iq2_i = '0; iq5_i = '0; iq6_i = '0;
    repeat (3) @(negedge clk);
    check("R8 reset value", int'(loop_o), 0);
    check("R8 reset valid", int'(loop_vld_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 after release value", int'(loop_o), 0);
    check("R8 after release valid", int'(loop_vld_o), 0);

    // directed corners
    apply("R1 fwd active drop", 1000, 200, 300, 40, 1'b1, 1);
    apply("R1 tip open drop", 1000, 200, 300, 40, 1'b1, 3);
    apply("R2 rev active drop", 1000, 200, 300, 40, 1'b1, 5);
    apply("R2 ring open drop", 1000, 200, 300, 40, 1'b1, 7);
    apply("R3 no flag", 1000, 200, 300, 40, 1'b0, 1);
    apply("R3 even code", 1000, 200, 300, 40, 1'b1, 2);
    apply("R4 plain sum", 50, 7, 11, 3, 1'b0, 0);
    apply("R5 floor of negative odd", 0, 0, 0, 3, 1'b0, 0);
    apply("R5 open undivided", 7, 0, 0, 0, 1'b0, 3);
    apply("R6 high clamp", 32767, -32768, 32767, -32768, 1'b0, 7);
    apply("R6 low clamp", -32768, 32767, -32768, 32767, 1'b0, 3);
    apply("R6 halved extreme", 32767, -32768, 32767, -32768, 1'b0, 0);

    // R7: strobe low, inputs change, output holds and valid stays low
    begin
      int held;
      held = int'($signed(loop_o));
      @(negedge clk);
      iq1_i = 16'd9999; iq5_i = 16'd1234; lfs_i = 3'd3;
      @(negedge clk);
      check("R7 valid low without strobe", int'(loop_vld_o), 0);
      check("R7 hold without strobe", int'($signed(loop_o)), held);
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      int v[4];
      for (int k = 0; k < 4; k++) begin
        case ($urandom_range(0, 5))
          0: v[k] = 32767;
          1: v[k] = -32768;
          default: v[k] = int'($signed(16'($urandom)));
        endcase
      end
      apply("R4 R5 random", v[0], v[1], v[2], v[3], 1'($urandom), int'($urandom_range(0, 7)));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule